// File: doc/BRIEF.md
# Double-Precision Operand Screen

This block looks at one 64-bit IEEE double operand on its way into a floating-point datapath and decides whether the operand belongs to a class that the datapath leaves to a trap handler. It splits the operand into exponent and fraction, classifies it, and then applies the rule set picked by a two-bit mode input. The three live modes cover ordinary arithmetic, comparisons, and software-completion instructions.

The result is three request lines: an invalid-operation trap, a qualifier that marks the trap for software completion, and a request to set the sticky invalid status flag. They are combinational and follow the inputs in the same cycle. They are asserted only while the operand-valid strobe is high. A flush-inputs-to-zero control affects only software-completion mode. In that mode, denormal inputs then pass through quietly.

Top module: `opscreen_unit`

## Requirements
- R1: The exponent is taken from operand bits 62:52 and the fraction from bits 51:0. Bit 63 (sign) has no influence on any output.
- R2: While opValid is low, trapReq, swcQual and stickyInvSet are all low, whatever the other inputs are.
- R3: In arithmetic mode (opMode = 2'b00), an operand with a zero exponent and a nonzero fraction drives trapReq high, with stickyInvSet and swcQual low.
- R4: In arithmetic mode, an operand whose exponent is all ones drives both trapReq and stickyInvSet high, whatever the fraction, with swcQual low.
- R5: In compare mode (opMode = 2'b01), a denormal traps without stickyInvSet. An all-ones exponent with a nonzero fraction traps with stickyInvSet. An all-ones exponent with a zero fraction produces no output.
- R6: In software-completion mode (opMode = 2'b10) with flushIn low, a denormal drives trapReq and swcQual high with stickyInvSet low. An all-ones exponent produces no output in this mode.
- R7: In software-completion mode with flushIn high, a denormal produces no output.
- R8: flushIn has no effect on any output in arithmetic or compare mode.
- R9: An operand with zero exponent and zero fraction, of either sign, never raises any output in any mode.
- R10: An operand with an exponent that is neither zero nor all ones never raises any output in any mode.
- R11: The reserved mode (opMode = 2'b11) never raises any output.
- R12: The outputs depend only on the present inputs, with no register between inputs and outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only by the embedded checks |
| rstN | input | 1 | Active-low reset; disables the embedded checks |
| opValid | input | 1 | Operand-valid strobe qualifying all outputs |
| opMode | input | 2 | Screening rule set: 00 arithmetic, 01 compare, 10 software completion, 11 reserved |
| flushIn | input | 1 | Flush-inputs-to-zero control |
| operand | input | 64 | IEEE double operand to screen |
| trapReq | output | 1 | Invalid-operation trap request |
| swcQual | output | 1 | Software-completion qualifier on the trap |
| stickyInvSet | output | 1 | Request to set the sticky invalid status flag |

## Verification
Two functions can act in the same cycle in software-completion mode: the denormal trap with its qualifier, and the flush control that suppresses that trap. The bench provokes this by applying denormals of both signs, in directed cases and random draws, with flushIn toggling independently in every mode. The outcome is judged against a bench model. With flush high, the outputs must stay low in software-completion mode. In arithmetic and compare modes, the same denormal must still trap without the sticky flag.

// File: rtl/opscreen_pkg.sv
package opscreen_pkg;

  typedef enum logic [1:0] {
    MODE_ARITH = 2'b00,
    MODE_CMP   = 2'b01,
    MODE_SWC   = 2'b10,
    MODE_RSVD  = 2'b11
  } scrMode_t;

  // Strobes that the classifier hands to the rule control
  typedef struct packed {
    logic negSign;
    logic expZero;
    logic expOnes;
    logic fracNz;
  } opClass_t;

endpackage

// File: rtl/opscreen_dp.sv
module opscreen_dp
  import opscreen_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  output opClass_t              opCls
);
  localparam int SIGN_POS = EXP_W + FRAC_W;
  localparam int EXP_LSB  = FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  assign expField  = operand[SIGN_POS-1:EXP_LSB];
  assign fracField = operand[FRAC_W-1:0];

  always_comb begin
    opCls.negSign = operand[SIGN_POS];
    opCls.expZero = (expField == '0);
    opCls.expOnes = &expField;
    opCls.fracNz  = |fracField;
  end
endmodule

// File: rtl/opscreen_ctl.sv
module opscreen_ctl
  import opscreen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     opValid,
  input  logic [1:0] opMode,
  input  logic     flushIn,
  input  opClass_t opCls,
  output logic     trapReq,
  output logic     swcQual,
  output logic     stickyInvSet
);
  logic isDenorm, isNan, isSpecial;
  scrMode_t modeSel;

  assign isDenorm  = opCls.expZero & opCls.fracNz;
  assign isSpecial = opCls.expOnes;
  assign isNan     = opCls.expOnes & opCls.fracNz;
  assign modeSel   = scrMode_t'(opMode);

  always_comb begin
    trapReq      = 1'b0;
    swcQual      = 1'b0;
    stickyInvSet = 1'b0;
    if (opValid) begin
      unique case (modeSel)
        MODE_ARITH: begin
          trapReq      = isDenorm | isSpecial;
          stickyInvSet = isSpecial;
        end
        MODE_CMP: begin
          trapReq      = isDenorm | isNan;
          stickyInvSet = isNan;
        end
        MODE_SWC: begin
          trapReq = isDenorm & ~flushIn;
          swcQual = isDenorm & ~flushIn;
        end
        default: ;
      endcase
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !(trapReq | swcQual | stickyInvSet));

  // R6
  swc_needs_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    swcQual |-> (trapReq && !stickyInvSet && opMode == 2'b10));

  // R4
  sticky_needs_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyInvSet |-> (trapReq && opCls.expOnes));

  // R7
  flush_swc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushIn && opMode == 2'b10) |-> !trapReq);

  // R9
  negzero_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCls.negSign && opCls.expZero && !opCls.fracNz) |-> !trapReq);

  // R11
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'b11) |-> !(trapReq | swcQual | stickyInvSet));
endmodule

// File: rtl/opscreen_unit.sv
module opscreen_unit
  import opscreen_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int OP_W  = EXP_W + FRAC_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [1:0]      opMode,
  input  logic            flushIn,
  input  logic [OP_W-1:0] operand,
  output logic            trapReq,
  output logic            swcQual,
  output logic            stickyInvSet
);
  opClass_t opCls;

  opscreen_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .operand (operand),
    .opCls   (opCls)
  );

  opscreen_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .opValid      (opValid),
    .opMode       (opMode),
    .flushIn      (flushIn),
    .opCls        (opCls),
    .trapReq      (trapReq),
    .swcQual      (swcQual),
    .stickyInvSet (stickyInvSet)
  );
endmodule

// File: tb/opscreen_unit_bench.sv
module opscreen_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opMode = 2'b00;
  logic flushIn = 1'b0;
  logic [63:0] operand = '0;
  logic trapReq, swcQual, stickyInvSet;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opscreen_unit u_opscreen_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opMode(opMode),
    .flushIn(flushIn), .operand(operand), .trapReq(trapReq),
    .swcQual(swcQual), .stickyInvSet(stickyInvSet)
  );

  // Model: returns {trap, swc, sticky}
  function automatic logic [2:0] model(input logic v, input logic [1:0] m,
                                       input logic fl, input logic [63:0] op);
    logic [10:0] e;
    logic [51:0] f;
    logic den, spc, nan;
    e = op[62:52];
    f = op[51:0];
    den = (e == 11'd0) && (f != 52'd0);
    spc = (e == 11'h7ff);
    nan = spc && (f != 52'd0);
    if (!v) return 3'b000;
    case (m)
      2'b00: return {den | spc, 1'b0, spc};
      2'b01: return {den | nan, 1'b0, nan};
      2'b10: return (den && !fl) ? 3'b110 : 3'b000;
      default: return 3'b000;
    endcase
  endfunction

  task automatic apply(input logic v, input logic [1:0] m, input logic fl,
                       input logic [63:0] op, input string req);
    logic [2:0] exp3;
    @(negedge clk);
    opValid = v; opMode = m; flushIn = fl; operand = op;
    #1;
    exp3 = model(v, m, fl, op);
    checks++;
    if ({trapReq, swcQual, stickyInvSet} !== exp3) begin
      failures++;
      $display("FAIL %s mode=%b flush=%b op=%h actual=%b expected=%b",
               req, m, fl, op, {trapReq, swcQual, stickyInvSet}, exp3);
    end
  endtask

  function automatic logic [63:0] pickOp(input int cls);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (cls)
      0: r[62:0] = '0;
      1: begin r[62:52] = '0; if (r[51:0] == 0) r[0] = 1'b1; end
      2: begin if (r[62:52] == 0 || r[62:52] == 11'h7ff) r[62:52] = 11'h3ff; end
      3: begin r[62:52] = 11'h7ff; r[51:0] = '0; end
      4: begin r[62:52] = 11'h7ff; if (r[51:0] == 0) r[51] = 1'b1; end
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    // Reset state: idle strobe, outputs low (R2)
    apply(1'b0, 2'b00, 1'b0, 64'h7ff8000000000000, "R2");
    rstN = 1'b1;
    @(posedge clk);
    apply(1'b0, 2'b01, 1'b0, 64'h0000000000000001, "R2");
    // Arithmetic
    apply(1'b1, 2'b00, 1'b0, 64'h0000000000000001, "R3");
    apply(1'b1, 2'b00, 1'b0, 64'h800fffffffffffff, "R3");
    apply(1'b1, 2'b00, 1'b0, 64'h7ff0000000000000, "R4");
    apply(1'b1, 2'b00, 1'b0, 64'hfff8000000000001, "R4");
    apply(1'b1, 2'b00, 1'b1, 64'h0000000000000001, "R8");
    // Compare
    apply(1'b1, 2'b01, 1'b0, 64'h7ff0000000000000, "R5");
    apply(1'b1, 2'b01, 1'b0, 64'hfff0000000000000, "R5");
    apply(1'b1, 2'b01, 1'b0, 64'h7ff0000000000001, "R5");
    apply(1'b1, 2'b01, 1'b1, 64'h8000000000000010, "R8");
    // Software completion
    apply(1'b1, 2'b10, 1'b0, 64'h0008000000000000, "R6");
    apply(1'b1, 2'b10, 1'b0, 64'h7ff8000000000000, "R6");
    apply(1'b1, 2'b10, 1'b1, 64'h0008000000000000, "R7");
    apply(1'b1, 2'b10, 1'b1, 64'h800000000000ffff, "R7");
    // Zeros, normals, reserved, field edges
    apply(1'b1, 2'b00, 1'b0, 64'h8000000000000000, "R9");
    apply(1'b1, 2'b01, 1'b0, 64'h0000000000000000, "R9");
    apply(1'b1, 2'b10, 1'b0, 64'h8000000000000000, "R9");
    apply(1'b1, 2'b00, 1'b0, 64'h0010000000000000, "R10");
    apply(1'b1, 2'b00, 1'b0, 64'h7fefffffffffffff, "R10");
    apply(1'b1, 2'b11, 1'b0, 64'h7ff8000000000000, "R11");
    apply(1'b1, 2'b11, 1'b0, 64'h0000000000000001, "R11");
    apply(1'b1, 2'b00, 1'b0, 64'h8000000000000000, "R1");
    apply(1'b1, 2'b01, 1'b0, 64'h7ff0000000000000, "R1");
    // Same-cycle response after input change (R12)
    apply(1'b1, 2'b00, 1'b0, 64'h3ff0000000000000, "R12");
    apply(1'b1, 2'b00, 1'b0, 64'h7ff0000000000000, "R12");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      apply(($urandom % 8) != 0, 2'($urandom), 1'($urandom),
            pickOp($urandom % 6), "R1_R3_R12");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule